// File: doc/BRIEF.md
# Per-antenna IQ frequency shifter

This block moves two independent complex baseband sample streams, one for each antenna, up or down in frequency by a coarse offset, and then scales the result by a power of two. The input rate is taken as 40 Msps. At that rate a 5 MHz step is one eighth of a turn per sample, so every offset the block supports is a whole number of 45-degree steps. Each antenna therefore has a 3-bit phase accumulator that indexes an eight-point cosine/sine set. Each valid sample is rotated by the current phase, rounded, shifted by the gain, and clamped to the signed 16-bit range.

One 32-bit configuration word sets the offset magnitude and direction for each antenna. A single signed gain field in the same word applies to both antennas. Changing an antenna's offset or direction restarts that antenna's phase at zero, so a new setting always begins from a known rotation. The block sits between the sample source and the downstream receiver. Its configuration is held in a register outside the block.

Top module: `iq_freq_shifter`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, every output sample is 0, and both phase accumulators are at 0.
- R2: A sample presented with its valid bit before a rising edge appears at the outputs after the third rising edge, counting that one. `out_valid[k]` repeats `in_valid[k]` with this same delay.
- R3: The configuration word uses these fields for antenna k (k = 0 or 1):
  - Bits [8k+1:8k] select the offset: 0 = 0 MHz, 1 = 5 MHz, 2 = 10 MHz, 3 = 15 MHz. The phase steps by that many eighths of a turn per valid sample.
  - Bit 8k+2 selects the direction: 0 = positive (the phase increases), 1 = negative (the phase decreases).
  - The bit positions are fixed because the register that drives the word decodes them.
- R4: At phase p, the output is `re = i*C - q*S` and `im = i*S + q*C`, where C and S are cos and sin of p*45 degrees, scaled by 65536. The axis values are ±65536, the diagonal values are ±46341, and off-axis components are 0. Each result is divided by 65536, rounding to nearest with ties toward plus infinity. With offset 0 and gain 0 the output equals the input exactly.
- R5: Bits [31:28] hold a two's-complement shift count g from −8 to +7, shared by both antennas. A positive g shifts left. A negative g shifts right arithmetically, which rounds toward minus infinity. For example, 2 multiplies by 4 and 0xF halves.
- R6: Results above 32767 are clamped to 32767, and results below −32768 are clamped to −32768. Results never wrap.
- R7: An antenna's phase restarts at 0 in any cycle where its 3-bit field differs from the value it held in the previous cycle. A sample valid in that cycle is rotated by phase 0. The other antenna's phase and a change of the gain field do not cause a restart.
- R8: The phase advances only on cycles where that antenna's input is valid. Idle cycles leave it unchanged.
- R9: The antennas are independent. Stimulus on one antenna, or its valid bit, has no effect on the other antenna's outputs or phase.
- R10: While `out_valid[k]` is low, `out_i[k]` and `out_q[k]` hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Offset, direction and gain configuration |
| in_valid | input | 2 | Per-antenna input sample strobe |
| in_i | input | 2x16 | Per-antenna in-phase input, signed |
| in_q | input | 2x16 | Per-antenna quadrature input, signed |
| out_valid | output | 2 | Per-antenna output sample strobe |
| out_i | output | 2x16 | Per-antenna in-phase output, signed |
| out_q | output | 2x16 | Per-antenna quadrature output, signed |

## Verification
A wrong phase accumulator shows as the wrong rotation on the next valid sample of that antenna, three edges later. Because phases differ by 45 degrees, a single-step error shows in both components at once. The bench therefore tracks the expected phase of each antenna across field changes, idle gaps and one-sided valid strobes, and checks every sample rather than only the first after a change. A wrong rounding or clamping stage shows only at a few values: diagonal phases, odd right shifts and full-scale inputs. The stimulus includes each of these.

// File: rtl/freqshift_pkg.sv
package freqshift_pkg;

    localparam int SAMPLE_W   = 16;
    localparam int COEF_W     = 18;
    localparam int COEF_FRAC  = 16;
    localparam int PHASE_W    = 3;
    localparam int NUM_ANT    = 2;
    localparam int GAIN_W     = 4;
    localparam int GAIN_LSB   = 28;
    localparam int FIELD_W    = 3;
    localparam int ANT_STRIDE = 8;
    localparam int PROD_W     = SAMPLE_W + COEF_W;
    localparam int ACC_W      = PROD_W + 1;
    localparam int ROT_W      = ACC_W - COEF_FRAC;
    localparam int WIDE_W     = ROT_W + (1 << (GAIN_W - 1));

    localparam logic signed [COEF_W-1:0] COEF_ONE  = COEF_W'(65536);
    localparam logic signed [COEF_W-1:0] COEF_DIAG = COEF_W'(46341);

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t re;
        sample_t im;
    } cplx_t;

    typedef struct packed {
        logic signed [COEF_W-1:0] c;
        logic signed [COEF_W-1:0] s;
    } rot_coef_t;

    typedef enum logic [1:0] {
        OFS_0MHZ  = 2'd0,
        OFS_5MHZ  = 2'd1,
        OFS_10MHZ = 2'd2,
        OFS_15MHZ = 2'd3
    } offset_code_e;

    typedef struct packed {
        logic         negative;
        offset_code_e code;
    } ant_cfg_t;

    function automatic ant_cfg_t ant_field(logic [31:0] cfg, int ant);
        return ant_cfg_t'(cfg[ant*ANT_STRIDE +: FIELD_W]);
    endfunction

    function automatic logic [PHASE_W-1:0] phase_step(ant_cfg_t f);
        logic [PHASE_W-1:0] mag;
        mag = PHASE_W'(f.code);
        return f.negative ? (PHASE_W'(0) - mag) : mag;
    endfunction

    // Eight points on the unit circle, 45 degrees apart, scaled by 2^COEF_FRAC
    function automatic rot_coef_t coef_at(logic [PHASE_W-1:0] ph);
        rot_coef_t r;
        unique case (ph)
            3'd0: begin r.c =  COEF_ONE;  r.s = '0;         end
            3'd1: begin r.c =  COEF_DIAG; r.s =  COEF_DIAG; end
            3'd2: begin r.c = '0;         r.s =  COEF_ONE;  end
            3'd3: begin r.c = -COEF_DIAG; r.s =  COEF_DIAG; end
            3'd4: begin r.c = -COEF_ONE;  r.s = '0;         end
            3'd5: begin r.c = -COEF_DIAG; r.s = -COEF_DIAG; end
            3'd6: begin r.c = '0;         r.s = -COEF_ONE;  end
            default: begin r.c = COEF_DIAG; r.s = -COEF_DIAG; end
        endcase
        return r;
    endfunction

    function automatic sample_t gain_saturate(logic signed [ROT_W-1:0] v,
                                              logic signed [GAIN_W-1:0] g);
        logic signed [WIDE_W-1:0] w;
        logic [GAIN_W-1:0]        amt;
        w = WIDE_W'(v);
        if (g[GAIN_W-1]) begin
            amt = GAIN_W'(-g);
            w   = w >>> amt;
        end else begin
            amt = g;
            w   = w <<< amt;
        end
        if ((&w[WIDE_W-1:SAMPLE_W-1]) || !(|w[WIDE_W-1:SAMPLE_W-1]))
            return w[SAMPLE_W-1:0];
        else if (w[WIDE_W-1])
            return {1'b1, {(SAMPLE_W-1){1'b0}}};
        else
            return {1'b0, {(SAMPLE_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/freqshift_phase.sv
module freqshift_phase
    import freqshift_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ant_cfg_t           field,
    input  logic               sample_valid,
    output logic [PHASE_W-1:0] phase_now
);
    ant_cfg_t           prev_field;
    logic [PHASE_W-1:0] phase_q;
    logic               field_changed;

    always_comb begin
        field_changed = (field != prev_field);
        phase_now     = field_changed ? '0 : phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_field <= ant_cfg_t'('0);
            phase_q    <= '0;
        end else begin
            prev_field <= field;
            phase_q    <= sample_valid ? (phase_now + phase_step(field)) : phase_now;
        end
    end
endmodule

// File: rtl/freqshift_rotator.sv
module freqshift_rotator
    import freqshift_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  cplx_t                    in_x,
    input  rot_coef_t                in_coef,
    input  logic signed [GAIN_W-1:0] in_gain,
    output logic                     out_valid,
    output logic signed [ROT_W-1:0]  out_re,
    output logic signed [ROT_W-1:0]  out_im,
    output logic signed [GAIN_W-1:0] out_gain
);
    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (COEF_FRAC - 1);

    logic signed [ACC_W-1:0] xr, xq, cc, ss, acc_re, acc_im;

    always_comb begin
        xr     = ACC_W'($signed(in_x.re));
        xq     = ACC_W'($signed(in_x.im));
        cc     = ACC_W'(in_coef.c);
        ss     = ACC_W'(in_coef.s);
        acc_re = xr * cc - xq * ss + HALF_LSB;
        acc_im = xr * ss + xq * cc + HALF_LSB;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
            out_gain  <= '0;
        end else begin
            out_valid <= in_valid;
            out_re    <= acc_re[ACC_W-1:COEF_FRAC];
            out_im    <= acc_im[ACC_W-1:COEF_FRAC];
            out_gain  <= in_gain;
        end
    end
endmodule

// File: rtl/freqshift_gain_sat.sv
module freqshift_gain_sat
    import freqshift_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [ROT_W-1:0]  in_re,
    input  logic signed [ROT_W-1:0]  in_im,
    input  logic signed [GAIN_W-1:0] in_gain,
    output logic                     out_valid,
    output cplx_t                    out_y
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_y     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_y.re <= gain_saturate(in_re, in_gain);
                out_y.im <= gain_saturate(in_im, in_gain);
            end
        end
    end
endmodule

// File: rtl/iq_freq_shifter.sv
module iq_freq_shifter
    import freqshift_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic [31:0]                        cfg_word,
    input  logic [NUM_ANT-1:0]                 in_valid,
    input  logic [NUM_ANT-1:0][SAMPLE_W-1:0]   in_i,
    input  logic [NUM_ANT-1:0][SAMPLE_W-1:0]   in_q,
    output logic [NUM_ANT-1:0]                 out_valid,
    output logic [NUM_ANT-1:0][SAMPLE_W-1:0]   out_i,
    output logic [NUM_ANT-1:0][SAMPLE_W-1:0]   out_q
);
    logic signed [GAIN_W-1:0] gain_cfg;
    assign gain_cfg = cfg_word[GAIN_LSB +: GAIN_W];

    for (genvar a = 0; a < NUM_ANT; a++) begin : g_ant
        ant_cfg_t                 field;
        logic [PHASE_W-1:0]       phase_now;
        logic                     s1_valid;
        cplx_t                    s1_x;
        rot_coef_t                s1_coef;
        logic signed [GAIN_W-1:0] s1_gain;
        logic                     s2_valid;
        logic signed [ROT_W-1:0]  s2_re, s2_im;
        logic signed [GAIN_W-1:0] s2_gain;
        logic                     s3_valid;
        cplx_t                    s3_y;

        assign field = ant_field(cfg_word, a);

        freqshift_phase u_phase (
            .clk          (clk),
            .rst          (rst),
            .field        (field),
            .sample_valid (in_valid[a]),
            .phase_now    (phase_now)
        );

        // Stage 1: capture the sample with the coefficients of its phase
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_valid <= 1'b0;
                s1_x     <= '0;
                s1_coef  <= '0;
                s1_gain  <= '0;
            end else begin
                s1_valid <= in_valid[a];
                s1_x.re  <= in_i[a];
                s1_x.im  <= in_q[a];
                s1_coef  <= coef_at(phase_now);
                s1_gain  <= gain_cfg;
            end
        end

        // Stage 2: complex rotation and rounding
        freqshift_rotator u_rot (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (s1_valid),
            .in_x      (s1_x),
            .in_coef   (s1_coef),
            .in_gain   (s1_gain),
            .out_valid (s2_valid),
            .out_re    (s2_re),
            .out_im    (s2_im),
            .out_gain  (s2_gain)
        );

        // Stage 3: gain shift and clamp
        freqshift_gain_sat u_gain (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (s2_valid),
            .in_re     (s2_re),
            .in_im     (s2_im),
            .in_gain   (s2_gain),
            .out_valid (s3_valid),
            .out_y     (s3_y)
        );

        assign out_valid[a] = s3_valid;
        assign out_i[a]     = s3_y.re;
        assign out_q[a]     = s3_y.im;
    end
endmodule

// File: rtl/iq_freq_shifter_chk.sv
module iq_freq_shifter_chk
    import freqshift_pkg::*;
(
    input logic                             clk,
    input logic                             rst,
    input logic [31:0]                      cfg_word,
    input logic [NUM_ANT-1:0]               in_valid,
    input logic [NUM_ANT-1:0][SAMPLE_W-1:0] in_i,
    input logic [NUM_ANT-1:0][SAMPLE_W-1:0] in_q,
    input logic [NUM_ANT-1:0]               out_valid,
    input logic [NUM_ANT-1:0][SAMPLE_W-1:0] out_i,
    input logic [NUM_ANT-1:0][SAMPLE_W-1:0] out_q
);
    // Cycles since reset, saturating at the pipeline depth
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        (warm != 2'd3) |-> (out_valid == '0));

    for (genvar a = 0; a < NUM_ANT; a++) begin : g_chk
        a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
            (warm == 2'd3) |-> (out_valid[a] == $past(in_valid[a], 3)));

        a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
            (warm == 2'd3 && !out_valid[a]) |-> ($stable(out_i[a]) && $stable(out_q[a])));

        a_r4_zero_offset_identity: assert property (@(posedge clk) disable iff (rst)
            (warm == 2'd3 && out_valid[a]
             && $past(cfg_word[a*ANT_STRIDE +: 2], 3) == 2'd0
             && $past(cfg_word[GAIN_LSB +: GAIN_W], 3) == '0)
            |-> (out_i[a] == $past(in_i[a], 3) && out_q[a] == $past(in_q[a], 3)));
    end
endmodule

bind iq_freq_shifter iq_freq_shifter_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_word  (cfg_word),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/test_iq_freq_shifter.sv
module test_iq_freq_shifter;
    logic              clk = 1'b0;
    logic              rst;
    logic [31:0]       cfg_word;
    logic [1:0]        in_valid;
    logic [1:0][15:0]  in_i, in_q;
    logic [1:0]        out_valid;
    logic [1:0][15:0]  out_i, out_q;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Bench model of the per-antenna phase (R3, R7, R8)
    int         m_phase [2];
    logic [2:0] m_prev  [2];
    int         exp_i   [2];
    int         exp_q   [2];

    iq_freq_shifter i_iq_freq_shifter (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #5 clk = ~clk;

    // stimulus: cfg, i0, q0, i1, q1
    localparam int NV = 16;
    localparam logic [95:0] VEC [NV] = '{
        {32'h0000_0000,  16'sd1000, -16'sd2000,   -16'sd5,     16'sd7},
        {32'h0000_0202,  16'sd1000,  16'sd0,       16'sd0,     16'sd300},
        {32'h0000_0202,  16'sd1000,  16'sd0,       16'sd0,     16'sd300},
        {32'h0000_0202, -16'sd1234,  16'sd4321,    16'sd77,   -16'sd99},
        {32'h0000_0101,  16'sd1,     16'sd1,       16'sd3,     16'sd0},
        {32'h0000_0101,  16'sd1,     16'sd1,       16'sd3,     16'sd0},
        {32'h0000_0101,  16'sd2000, -16'sd3000,   -16'sd7,     16'sd9},
        {32'h0000_0405,  16'sd500,   16'sd250,    -16'sd500,   16'sd250},
        {32'h0000_0405,  16'sd500,   16'sd250,    -16'sd500,   16'sd250},
        {32'h2000_0405,  16'sd500,  -16'sd250,     16'sd1000,  16'sd11},
        {32'hF000_0303,  16'sd3,    -16'sd3,       16'sd1001, -16'sd777},
        {32'hF000_0303,  16'sd3,    -16'sd3,       16'sd1001, -16'sd777},
        {32'h7000_0000,  16'sd300,   16'sd0,      -16'sd300,   16'sd1},
        {32'h0000_0002, -16'sd32768,-16'sd32768,   16'sd32767, 16'sd32767},
        {32'h0000_0002, -16'sd32768,-16'sd32768,   16'sd32767,-16'sd32768},
        {32'h8000_0600, -16'sd3,     16'sd255,     16'sd255,  -16'sd3}
    };

    function automatic int exp_comp(int xi, int xq, int ph, bit want_q, int g);
        longint c, s, v, r;
        case (ph)
            0: begin c =  65536; s =      0; end
            1: begin c =  46341; s =  46341; end
            2: begin c =      0; s =  65536; end
            3: begin c = -46341; s =  46341; end
            4: begin c = -65536; s =      0; end
            5: begin c = -46341; s = -46341; end
            6: begin c =      0; s = -65536; end
            default: begin c = 46341; s = -46341; end
        endcase
        v = want_q ? (xi * s + xq * c) : (xi * c - xq * s);
        r = (v + 32768) >>> 16;
        if (g >= 0) r = r <<< g;
        else        r = r >>> (-g);
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < 2; a++) begin
            m_phase[a] = 0;
            m_prev[a]  = 3'd0;
            exp_i[a]   = 0;
            exp_q[a]   = 0;
        end
    endtask

    // One sample cycle then check after the third edge (R2)
    task automatic run_sample(input logic [31:0] cfg, input logic [1:0] vmask,
                              input int i0, input int q0, input int i1, input int q1,
                              input string req);
        int xi [2];
        int xq [2];
        int g;
        xi[0] = i0; xq[0] = q0; xi[1] = i1; xq[1] = q1;
        g = int'($signed(cfg[31:28]));
        @(negedge clk);
        cfg_word = cfg;
        in_valid = vmask;
        in_i[0] = 16'(i0); in_q[0] = 16'(q0);
        in_i[1] = 16'(i1); in_q[1] = 16'(q1);
        for (int a = 0; a < 2; a++) begin
            logic [2:0] fld;
            int step;
            fld = cfg[a*8 +: 3];
            if (fld != m_prev[a]) m_phase[a] = 0;
            m_prev[a] = fld;
            step = fld[2] ? ((8 - int'(fld[1:0])) & 7) : int'(fld[1:0]);
            if (vmask[a]) begin
                exp_i[a]   = exp_comp(xi[a], xq[a], m_phase[a], 1'b0, g);
                exp_q[a]   = exp_comp(xi[a], xq[a], m_phase[a], 1'b1, g);
                m_phase[a] = (m_phase[a] + step) & 7;
            end
        end
        @(negedge clk);
        in_valid = 2'b00;
        @(negedge clk);
        @(negedge clk);
        check({"R2 valid ", req}, int'(out_valid), int'(vmask));
        for (int a = 0; a < 2; a++) begin
            check({"R4 re ", req}, int'($signed(out_i[a])), exp_i[a]);
            check({"R4 im ", req}, int'($signed(out_q[a])), exp_q[a]);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; cfg_word = '0; in_valid = '0; in_i = '0; in_q = '0;
        model_reset();
        idle(3);
        rst = 1'b0;
        // R1: reset state
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 data after reset", int'(out_i) | int'(out_q), 0);

        // Table walk: offsets, signs, gains, rounding, clamping (R3 R4 R5 R6 R7)
        for (int n = 0; n < NV; n++) begin
            run_sample(VEC[n][95:64], 2'b11,
                       int'($signed(VEC[n][63:48])), int'($signed(VEC[n][47:32])),
                       int'($signed(VEC[n][31:16])), int'($signed(VEC[n][15:0])),
                       $sformatf("R3 R5 R6 vector %0d", n));
        end

        // R10: outputs hold while valid is low
        idle(2);
        check("R10 hold valid", int'(out_valid), 0);
        for (int a = 0; a < 2; a++) begin
            check("R10 hold re", int'($signed(out_i[a])), exp_i[a]);
            check("R10 hold im", int'($signed(out_q[a])), exp_q[a]);
        end

        // R8 / R9: one-sided valid and idle gaps do not advance the other phase
        run_sample(32'h0000_0101, 2'b11, 1000, 0, 1000, 0, "R8 start");
        run_sample(32'h0000_0101, 2'b01, 1000, 0, 1000, 0, "R9 ant0 only");
        idle(5);
        run_sample(32'h0000_0101, 2'b11, 1000, 0, 1000, 0, "R8 after gap");
        run_sample(32'h0000_0101, 2'b10, 500, 500, 500, 500, "R9 ant1 only");
        run_sample(32'h0000_0101, 2'b11, 500, 500, 500, 500, "R8 R9 both");

        // R7: changing ant1 field restarts only ant1; gain change restarts nothing
        run_sample(32'h0000_0501, 2'b11, 800, -600, 800, -600, "R7 ant1 restart");
        run_sample(32'h3000_0501, 2'b11, 800, -600, 800, -600, "R7 gain no restart");
        run_sample(32'h0000_0501, 2'b11, 800, -600, 800, -600, "R7 continue");

        // R6: clamp at both rails with the largest gain
        run_sample(32'h7000_0000, 2'b11, 32767, -32768, -256, 255, "R6 rails");

        // R1: reset in mid-stream clears outputs and phases
        @(negedge clk);
        in_valid = 2'b11;
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        in_valid = 2'b00;
        model_reset();
        check("R1 valid after mid reset", int'(out_valid), 0);
        check("R1 data after mid reset", int'(out_i) | int'(out_q), 0);
        run_sample(32'h0000_0201, 2'b11, 100, 200, 100, 200, "R1 phase zero");
        run_sample(32'h0000_0201, 2'b11, 100, 200, 100, 200, "R1 phase step");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule